// File: doc/BRIEF.md
# Hash Message-Expansion Partial-Word Unit

This block performs one partial-word step of the message expansion used by a 256-bit iterative hash. It accepts three 128-bit operands: an accumulator, a second operand and a third operand. Each operand is split into four 32-bit lanes, with lane 0 at bits 31:0 and lane 3 at bits 127:96. The block returns a 128-bit result, and the surrounding core writes that result back over the accumulator.

Each lane ends with a permutation: the lane's intermediate value is xored with itself rotated left by 15 and with itself rotated left by 23. The top lane cannot start until lane 0 has been permuted. The datapath is therefore split over two register stages. The first stage finishes lanes 0 to 2. The second stage finishes lane 3 from the registered lane 0. This gives a constant two-cycle latency and lets a new operation enter on every cycle.

A separate combinational decode check examines a 32-bit instruction word together with a feature-enable input. It reports whether the word is legal or undefined, and it extracts three 5-bit register indices.

Top module: `hmx_partw_top`

## Requirements
- R1: For lanes 0, 1 and 2, the intermediate value is (acc xor opn) of that lane xored with lane i+1 of opm rotated left by 15.
- R2: Every lane's final value is x ^ rol(x,15) ^ rol(x,23), where x is that lane's intermediate value.
- R3: The lane 3 intermediate value is (acc xor opn) lane 3 xored with the final lane 0 result rotated left by 15. Lane 0 of opm has no effect on the result.
- R4: out_valid rises exactly two clock edges after in_valid is sampled high, whatever the operand values.
- R5: A new operation is accepted on every cycle with in_valid high. Back-to-back operations produce back-to-back results in order.
- R6: While rst_n is low at a clock edge (synchronous, active low), out_valid and out_result are cleared to zero.
- R7: When out_valid is low, out_result keeps its previous value.
- R8: A word with bits 31:21 = 11001110011 and bits 15:10 = 110000, with feat_en high, gives dec_legal=1 and dec_undef=0.
- R9: A matching word with feat_en low gives dec_undef=1 and dec_legal=0.
- R10: A word that does not match both fields gives dec_legal=0 and dec_undef=0.
- R11: dec_rm is bits 20:16, dec_rn is bits 9:5 and dec_rd is bits 4:0 of the word, whether or not the word matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| in_acc | input | 128 | Accumulator operand (also the destination) |
| in_opn | input | 128 | Second operand |
| in_opm | input | 128 | Third operand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 128 | Expanded result |
| insn_word | input | 32 | Instruction word to decode |
| feat_en | input | 1 | Feature enable for the decode check |
| dec_legal | output | 1 | Word matches and the feature is enabled |
| dec_undef | output | 1 | Word matches but the feature is disabled |
| dec_rd | output | 5 | Destination/accumulator index |
| dec_rn | output | 5 | Second-operand index |
| dec_rm | output | 5 | Third-operand index |

## Verification
Suppose the registered lane 0 value or the carried (acc xor opn) top lane is wrong between the stages. The error then shows only in lanes 3 and 0 of the result, exactly two edges after the operation entered, so the per-cycle comparison localises it to that stage. A lost or duplicated valid bit shows as an out_valid that is one cycle early, one cycle late or missing, against the bench's two-entry model. A stale result register shows when out_valid is low, as a change in out_result. Decode faults appear immediately on the combinational outputs for the directed words.

// File: rtl/hmx_pkg.sv
// Package: shared widths and constants for the partial-word expansion unit.
// Assumes lanes are LANE_W bits and lane 0 sits in the least significant bits.
package hmx_pkg;
    localparam int LANE_W   = 32;
    localparam int N_LANES  = 4;
    localparam int DATA_W   = LANE_W * N_LANES;
    localparam int ROT_M    = 15;   // rotation applied to the third operand
    localparam int ROT_FB   = 15;   // rotation on the lane 0 feedback into lane 3
    localparam int ROT_P_A  = 15;   // permutation rotation A
    localparam int ROT_P_B  = 23;   // permutation rotation B
    localparam int IDX_W    = 5;

    localparam logic [10:0] OPC_HI  = 11'b11001110011;  // word bits 31:21
    localparam logic [5:0]  OPC_MID = 6'b110000;        // word bits 15:10

    // Rotate a lane left by a fixed amount.
    function automatic logic [LANE_W-1:0] rol_lane(input logic [LANE_W-1:0] x, input int sh);
        logic [2*LANE_W-1:0] tmp;
        tmp = {x, x} << sh;
        return tmp[2*LANE_W-1:LANE_W];
    endfunction
endpackage

// File: rtl/hmx_lane_mix.sv
// Module: hmx_lane_mix
// Applies the lane permutation y = x ^ rol(x,RA) ^ rol(x,RB).
// Purely combinational; assumes 0 < RA, RB < W.
module hmx_lane_mix #(
    parameter int W  = 32,
    parameter int RA = 15,
    parameter int RB = 23
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W-1:0] rot_a;
    logic [W-1:0] rot_b;

    assign rot_a = {x[W-1-RA:0], x[W-1:W-RA]};
    assign rot_b = {x[W-1-RB:0], x[W-1:W-RB]};

    // Three-way xor of the lane with its two rotations.
    always_comb begin
        y = x ^ rot_a ^ rot_b;
    end
endmodule

// File: rtl/hmx_stage1.sv
// Module: hmx_stage1
// First pipeline stage: finishes lanes 0..LANES-2 and registers them,
// together with (acc xor opn) of the top lane, for use by stage 2.
// Assumes synchronous active-low reset; data registers load only on valid.
module hmx_stage1
    import hmx_pkg::*;
#(
    parameter int W     = LANE_W,
    parameter int LANES = N_LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [W*LANES-1:0]     in_acc,
    input  logic [W*LANES-1:0]     in_opn,
    input  logic [W*LANES-1:0]     in_opm,
    output logic                   s1_valid,
    output logic [W*(LANES-1)-1:0] s1_low,
    output logic [W-1:0]           s1_top_dn
);
    localparam int LOW_W = W * (LANES - 1);

    logic [W*LANES-1:0] dn;
    logic [LOW_W-1:0]   low_pre;
    logic [LOW_W-1:0]   low_fin;

    assign dn = in_acc ^ in_opn;

    for (genvar i = 0; i < LANES - 1; i++) begin : g_low
        // Intermediate value: own (acc^opn) lane xor rotated next-higher opm lane.
        always_comb begin
            low_pre[i*W +: W] = dn[i*W +: W] ^ rol_lane(in_opm[(i+1)*W +: W], ROT_M);
        end

        hmx_lane_mix #(.W(W), .RA(ROT_P_A), .RB(ROT_P_B)) u_mix (
            .x (low_pre[i*W +: W]),
            .y (low_fin[i*W +: W])
        );
    end

    // Stage register: valid always tracks input, data loads only with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_low    <= '0;
            s1_top_dn <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_low    <= low_fin;
                s1_top_dn <= dn[(LANES-1)*W +: W];
            end
        end
    end
endmodule

// File: rtl/hmx_stage2.sv
// Module: hmx_stage2
// Second pipeline stage: finishes the top lane from the registered lane 0
// result and registers the full output word.
// Assumes stage 1 holds its data when its valid is low.
module hmx_stage2
    import hmx_pkg::*;
#(
    parameter int W     = LANE_W,
    parameter int LANES = N_LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s1_valid,
    input  logic [W*(LANES-1)-1:0] s1_low,
    input  logic [W-1:0]           s1_top_dn,
    output logic                   out_valid,
    output logic [W*LANES-1:0]     out_result
);
    logic [W-1:0] top_pre;
    logic [W-1:0] top_fin;

    // Top-lane intermediate: carried (acc^opn) xor rotated finished lane 0.
    always_comb begin
        top_pre = s1_top_dn ^ rol_lane(s1_low[W-1:0], ROT_FB);
    end

    hmx_lane_mix #(.W(W), .RA(ROT_P_A), .RB(ROT_P_B)) u_mix_top (
        .x (top_pre),
        .y (top_fin)
    );

    // Output register: holds its value between valid results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_result <= {top_fin, s1_low};
            end
        end
    end
endmodule

// File: rtl/hmx_decode.sv
// Module: hmx_decode
// Combinational legality check of a 32-bit instruction word and extraction
// of the three register indices. Assumes the fixed opcode fields of hmx_pkg.
module hmx_decode
    import hmx_pkg::*;
(
    input  logic [31:0]      insn_word,
    input  logic             feat_en,
    output logic             dec_legal,
    output logic             dec_undef,
    output logic [IDX_W-1:0] dec_rd,
    output logic [IDX_W-1:0] dec_rn,
    output logic [IDX_W-1:0] dec_rm
);
    logic pat_hit;

    // Pattern match on both fixed fields.
    always_comb begin
        pat_hit = (insn_word[31:21] == OPC_HI) && (insn_word[15:10] == OPC_MID);
    end

    // Classify: legal only with the feature enabled, undefined otherwise.
    always_comb begin
        dec_legal = pat_hit && feat_en;
        dec_undef = pat_hit && !feat_en;
    end

    // Index fields are extracted unconditionally.
    always_comb begin
        dec_rm = insn_word[20:16];
        dec_rn = insn_word[9:5];
        dec_rd = insn_word[4:0];
    end
endmodule

// File: rtl/hmx_partw_top.sv
// Module: hmx_partw_top
// Two-stage partial-word message-expansion datapath plus decode check.
// Fixed latency of two cycles, one operation per cycle, no backpressure.
module hmx_partw_top
    import hmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [127:0]      in_acc,
    input  logic [127:0]      in_opn,
    input  logic [127:0]      in_opm,
    output logic              out_valid,
    output logic [127:0]      out_result,
    input  logic [31:0]       insn_word,
    input  logic              feat_en,
    output logic              dec_legal,
    output logic              dec_undef,
    output logic [4:0]        dec_rd,
    output logic [4:0]        dec_rn,
    output logic [4:0]        dec_rm
);
    localparam int LOW_W = LANE_W * (N_LANES - 1);

    logic             s1_valid;
    logic [LOW_W-1:0] s1_low;
    logic [LANE_W-1:0] s1_top_dn;

    hmx_stage1 #(.W(LANE_W), .LANES(N_LANES)) u_s1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_acc    (in_acc),
        .in_opn    (in_opn),
        .in_opm    (in_opm),
        .s1_valid  (s1_valid),
        .s1_low    (s1_low),
        .s1_top_dn (s1_top_dn)
    );

    hmx_stage2 #(.W(LANE_W), .LANES(N_LANES)) u_s2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_low     (s1_low),
        .s1_top_dn  (s1_top_dn),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    hmx_decode u_dec (
        .insn_word (insn_word),
        .feat_en   (feat_en),
        .dec_legal (dec_legal),
        .dec_undef (dec_undef),
        .dec_rd    (dec_rd),
        .dec_rn    (dec_rn),
        .dec_rm    (dec_rm)
    );
endmodule

// File: rtl/hmx_partw_chk.sv
// Module: hmx_partw_chk
// Protocol and decode checks bound onto hmx_partw_top. Keeps its own
// two-entry valid shadow to check latency without deep $past.
module hmx_partw_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [127:0] out_result,
    input logic [31:0]  insn_word,
    input logic         feat_en,
    input logic         dec_legal,
    input logic         dec_undef
);
    logic [1:0] vshadow;

    // Shadow of in_valid delayed by two edges.
    always_ff @(posedge clk) begin
        if (!rst_n) vshadow <= 2'b00;
        else        vshadow <= {vshadow[0], in_valid};
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vshadow[1]);  // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result));  // R7

    AST_DEC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_legal, dec_undef}));  // R8

    AST_DEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |-> !dec_legal);  // R9

    AST_DEC_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_word[15:10] != 6'b110000) |-> !(dec_legal || dec_undef));  // R10
endmodule

bind hmx_partw_top hmx_partw_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_result (out_result),
    .insn_word  (insn_word),
    .feat_en    (feat_en),
    .dec_legal  (dec_legal),
    .dec_undef  (dec_undef)
);

// File: tb/tb_hmx_partw_top.sv
module tb_hmx_partw_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_acc, in_opn, in_opm;
    logic         out_valid;
    logic [127:0] out_result;
    logic [31:0]  insn_word;
    logic         feat_en;
    logic         dec_legal, dec_undef;
    logic [4:0]   dec_rd, dec_rn, dec_rm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state: two-entry pipeline plus last delivered result
    bit           mv[2];
    logic [127:0] md[2];
    logic [127:0] last_res;

    always #2 clk = ~clk;  // 250 MHz

    hmx_partw_top dut (.*);

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    // behavioural reference, lanes run strictly in order 0..3
    function automatic logic [127:0] ref_calc(input logic [127:0] a, n, m);
        logic [31:0] r[4];
        logic [31:0] x;
        for (int i = 0; i < 4; i++) begin
            x = a[32*i +: 32] ^ n[32*i +: 32];
            if (i < 3) x = x ^ rl(m[32*(i+1) +: 32], 15);
            else       x = x ^ rl(r[0], 15);
            r[i] = x ^ rl(x, 15) ^ rl(x, 23);
        end
        return {r[3], r[2], r[1], r[0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: compare outputs against model, advance model, drive inputs
    task automatic cyc(input bit v, input logic [127:0] a, n, m);
        @(negedge clk);
        chk(out_valid == mv[1], "R4/R5 valid timing", 128'(out_valid), 128'(mv[1]));
        if (mv[1]) begin
            chk(out_result == md[1], "R1/R2/R3 result", out_result, md[1]);
            last_res = md[1];
        end else begin
            chk(out_result == last_res, "R7 hold", out_result, last_res);
        end
        mv[1] = mv[0]; md[1] = md[0];
        mv[0] = v;     md[0] = ref_calc(a, n, m);
        in_valid = v; in_acc = a; in_opn = n; in_opm = m;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic dec_chk(input logic [31:0] w, input bit fe, input bit el, eu);
        insn_word = w; feat_en = fe;
        #1;
        chk({dec_legal, dec_undef} == {el, eu}, (el ? "R8 legal" : (eu ? "R9 undef" : "R10 nomatch")),
            128'({dec_legal, dec_undef}), 128'({el, eu}));
        chk({dec_rm, dec_rn, dec_rd} == {w[20:16], w[9:5], w[4:0]}, "R11 indices",
            128'({dec_rm, dec_rn, dec_rd}), 128'({w[20:16], w[9:5], w[4:0]}));
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0;
        in_acc = '0; in_opn = '0; in_opm = '0;
        insn_word = '0; feat_en = 1'b0;
        mv[0] = 0; mv[1] = 0; md[0] = '0; md[1] = '0; last_res = '0;
        // drive a valid during reset to confirm it is dropped
        @(negedge clk); in_valid = 1'b1; in_acc = '1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R6 reset valid", 128'(out_valid), 128'(0));
        chk(out_result == '0, "R6 reset result", out_result, '0);
        in_valid = 1'b0; in_acc = '0;
        rst_n = 1'b1;

        // directed vectors
        cyc(1, '0, '0, '0);
        cyc(1, '1, '0, '0);
        cyc(1, '0, '1, '0);
        cyc(1, '0, '0, '1);
        cyc(1, '1, '1, '1);
        for (int l = 0; l < 4; l++) begin
            cyc(1, 128'(1) << (32*l), '0, '0);
            cyc(1, '0, 128'(1) << (32*l + 7), '0);
            cyc(1, '0, '0, 128'(1) << (32*l + 31));
        end
        // R3: opm lane 0 alone must give zero
        cyc(1, '0, '0, 128'hFFFF_FFFF);
        cyc(0, '0, '0, '0);
        cyc(0, '0, '0, '0);
        chk(last_res == '0 && out_result == '0, "R3 opm lane0 unused", out_result, '0);
        // random traffic, back-to-back bursts with gaps
        for (int k = 0; k < 1200; k++) begin
            cyc(($urandom % 5) != 0, rnd128(), rnd128(), rnd128());
        end
        for (int k = 0; k < 3; k++) cyc(0, rnd128(), rnd128(), rnd128());

        // decode checks
        for (int k = 0; k < 20; k++) begin
            logic [4:0] a, b, c;
            a = 5'($urandom); b = 5'($urandom); c = 5'($urandom);
            dec_chk({11'b11001110011, a, 6'b110000, b, c}, 1, 1, 0);
            dec_chk({11'b11001110011, a, 6'b110000, b, c}, 0, 0, 1);
            dec_chk({11'b11001110010, a, 6'b110000, b, c}, 1, 0, 0);
            dec_chk({11'b11001110011, a, 6'b110001, b, c}, 1, 0, 0);
            dec_chk({11'b01001110011, a, 6'b010000, b, c}, 0, 0, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule